// File: doc/BRIEF.md
# Divider Sequencing Controller

This block drives the two control lines of an iterative radix-2 divider. A request input, sampled on rising clock edges, starts a sequence: the controller leaves idle, raises a one-cycle start pulse, and keeps a hold line high while the divider runs a fixed number of quotient iterations (eight by default). The controller then reaches a final state.

The divider's result settles on a falling clock edge. For that reason the hold line is not dropped by a rising-edge decode. Instead, a falling-edge flip-flop captures the "final state" flag and masks the hold line half a cycle after the final state is entered, before the next rising edge can alter the quotient. The controller stays in the final state while the request remains high. It returns to idle on the first rising edge that samples the request low. A synchronous clear returns everything to idle.

Top module: `divseq_ctrl`

## Requirements
- R1: While idle and `div_req` is sampled low at a rising edge, the controller stays idle, and `go_pulse` and `run_hold` are both 0.
- R2: A rising edge that samples `div_req` high while idle makes `go_pulse` 1 for exactly the following clock cycle. `go_pulse` is 0 at all other times.
- R3: After the `go_pulse` cycle, the controller spends ITERS-1 further run cycles (ITERS run cycles in total) and then enters the final state.
- R4: `run_hold` is 1 from the rising edge that starts the `go_pulse` cycle, through every run cycle, up to the first falling edge in the final state.
- R5: Once started, the run cycles advance one per rising edge whatever the value of `div_req`.
- R6: In the final state, `run_hold` goes to 0 at the falling edge within the first final cycle and stays 0. The controller stays final while `div_req` is sampled high. It returns to idle on the first rising edge that samples `div_req` low, and it stays idle for at least one cycle.
- R7: `hard_clr` sampled high at a rising edge forces idle, so both outputs are 0 after that edge. `hard_clr` sampled high at a falling edge clears the falling-edge cancel flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The sequencer uses the rising edge and the cancel flag uses the falling edge. |
| hard_clr | input | 1 | Synchronous clear to idle, active high. |
| div_req | input | 1 | Division request. It starts a sequence when idle and holds the final state while high. |
| go_pulse | output | 1 | One-cycle start pulse to the divider. |
| run_hold | output | 1 | Hold/enable to the divider. It drops half a cycle into the final state. |

## Verification
The hardest situation to reach is `hard_clr` landing at an arbitrary point of a sequence, including the final state when the cancel flag is already set. The same applies to a new request that arrives just as the final state is left. The bench sweeps several hundred request bit patterns across whole sequences and injects clears at varying cycle offsets. It checks both half-cycles of every clock period against a cycle model built from the requirements, so the falling-edge mask is observed separately from the rising-edge state.

// File: rtl/divseq_pkg.sv
package divseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FINAL = 2'd2
    } phase_e;

endpackage

// File: rtl/divseq_fsm.sv
module divseq_fsm
    import divseq_pkg::*;
#(
    parameter int ITERS = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic req,
    output logic go_o,
    output logic busy_o,
    output logic final_o
);
    localparam int CW = (ITERS > 2) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    typedef struct packed {
        phase_e         ph;
        logic [CW-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req) begin
                    seq_d.ph  = PH_RUN;
                    seq_d.cnt = '0;
                end
            end
            PH_RUN: begin
                if (seq_q.cnt == LAST) begin
                    seq_d.ph  = PH_FINAL;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            PH_FINAL: begin
                if (!req) seq_d.ph = PH_IDLE;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
        if (clr) begin
            seq_d.ph  = PH_IDLE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign go_o    = (seq_q.ph == PH_RUN) && (seq_q.cnt == '0);
    assign busy_o  = (seq_q.ph != PH_IDLE);
    assign final_o = (seq_q.ph == PH_FINAL);

    // R1
    a_r1_idle_stays: assert property (@(posedge clk) disable iff (clr)
        (seq_q.ph == PH_IDLE && !req) |=> (seq_q.ph == PH_IDLE));
    // R2
    a_r2_go_follows_req: assert property (@(posedge clk) disable iff (clr)
        (seq_q.ph == PH_IDLE && req) |=> go_o);
    a_r2_go_single: assert property (@(posedge clk) disable iff (clr)
        go_o |=> !go_o);
    // R5
    a_r5_run_advances: assert property (@(posedge clk) disable iff (clr)
        (seq_q.ph == PH_RUN && seq_q.cnt != LAST) |=>
        (seq_q.ph == PH_RUN && seq_q.cnt == $past(seq_q.cnt) + CW'(1)));
    // R3
    a_r3_run_to_final: assert property (@(posedge clk) disable iff (clr)
        (seq_q.ph == PH_RUN && seq_q.cnt == LAST) |=> final_o);
    // R6
    a_r6_final_waits: assert property (@(posedge clk) disable iff (clr)
        (final_o && req) |=> final_o);
    a_r6_final_exit: assert property (@(posedge clk) disable iff (clr)
        (final_o && !req) |=> (seq_q.ph == PH_IDLE));
    // R7
    a_r7_clear_idle: assert property (@(posedge clk)
        clr |=> (seq_q.ph == PH_IDLE));

endmodule

// File: rtl/divseq_negcap.sv
module divseq_negcap (
    input  logic clk,
    input  logic clr,
    input  logic flag_i,
    output logic cancel_o
);
    logic cancel_d, cancel_q;

    always_comb begin
        cancel_d = clr ? 1'b0 : flag_i;
    end

    always_ff @(negedge clk) begin
        cancel_q <= cancel_d;
    end

    assign cancel_o = cancel_q;

    // R7
    a_r7_cancel_clear: assert property (@(negedge clk)
        clr |=> !cancel_q);

endmodule

// File: rtl/divseq_ctrl.sv
module divseq_ctrl #(
    parameter int ITERS = 8
) (
    input  logic clk,
    input  logic hard_clr,
    input  logic div_req,
    output logic go_pulse,
    output logic run_hold
);
    logic busy, fin, cancel;

    divseq_fsm #(.ITERS(ITERS)) u_fsm (
        .clk    (clk),
        .clr    (hard_clr),
        .req    (div_req),
        .go_o   (go_pulse),
        .busy_o (busy),
        .final_o(fin)
    );

    divseq_negcap u_cap (
        .clk     (clk),
        .clr     (hard_clr),
        .flag_i  (fin),
        .cancel_o(cancel)
    );

    assign run_hold = busy & ~cancel;

    // R4
    a_r4_hold_with_go: assert property (@(posedge clk) disable iff (hard_clr)
        go_pulse |-> run_hold);
    // R6
    a_r6_final_masked: assert property (@(posedge clk) disable iff (hard_clr)
        fin |-> !run_hold);

endmodule

// File: tb/test_divseq_ctrl.sv
module test_divseq_ctrl;
    localparam int CLK_P = 10;
    localparam int ITERS = 8;
    localparam int FINAL = ITERS + 1;

    logic clk = 1'b0;
    logic hard_clr = 1'b1;
    logic div_req = 1'b0;
    logic go_pulse, run_hold;

    int n_chk = 0;
    int n_bad = 0;
    int m_idx = 0;       // 0 idle, 1..ITERS run, FINAL final
    bit m_cancel = 1'b0;
    bit m_clr_prev = 1'b0;
    bit m_req_prev = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    divseq_ctrl #(.ITERS(ITERS)) i_divseq_ctrl (
        .clk     (clk),
        .hard_clr(hard_clr),
        .div_req (div_req),
        .go_pulse(go_pulse),
        .run_hold(run_hold)
    );

    function automatic string tag_of();
        if (m_clr_prev) return "R7";
        if (m_idx == 0) return "R1";
        if (m_idx == 1) return "R2";
        if (m_idx == FINAL) return "R6";
        if (!m_req_prev) return "R5";
        return "R4";
    endfunction

    task automatic check(input string half);
        bit eg, eh;
        eg = (m_idx == 1);
        eh = (m_idx != 0) && !m_cancel;
        n_chk++;
        if (go_pulse !== eg) begin
            n_bad++;
            $display("FAIL %s/R2 go_pulse %s half idx=%0d: got %b exp %b",
                     tag_of(), half, m_idx, go_pulse, eg);
        end
        n_chk++;
        if (run_hold !== eh) begin
            n_bad++;
            $display("FAIL %s/R4 run_hold %s half idx=%0d: got %b exp %b",
                     tag_of(), half, m_idx, run_hold, eh);
        end
    endtask

    // Inputs are set 2 units before the rising edge. The model is then
    // advanced and checked in both halves of the cycle.
    task automatic cycle(input bit req, input bit clr);
        div_req  = req;
        hard_clr = clr;
        @(posedge clk);
        if (clr) m_idx = 0;
        else if (m_idx == 0) m_idx = req ? 1 : 0;
        else if (m_idx == FINAL) m_idx = req ? FINAL : 0;
        else m_idx = m_idx + 1;              // R3, R5: chain ignores req
        m_clr_prev = clr;
        m_req_prev = req;
        #3;
        check("first");
        @(negedge clk);
        m_cancel = clr ? 1'b0 : (m_idx == FINAL);
        #3;
        check("second");
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P - 2);
        // R7: reset state
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
        // R1: idle with request low
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
        // R6: final state held for several lengths
        for (int h = 0; h < 5; h++) begin
            for (int i = 0; i < ITERS + 1 + h; i++) cycle(1'b1, 1'b0);
            for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);
        end
        // R5 and R7: request patterns and clears at varying offsets
        for (int p = 0; p < 512; p++) begin
            int cpos;
            cpos = (p % 3 == 0) ? (p % 16) : -1;
            cycle(1'b1, 1'b0);
            for (int i = 0; i < 14; i++)
                cycle(((p >> (i % 9)) & 1) == 1, i == cpos);
            for (int i = 0; i < 2; i++) cycle(1'b0, 1'b0);
        end
        // R2: back-to-back requests with request held high
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule